// File: doc/BRIEF.md
# Virtual-Channel Mesh Router

This block is one node router of a two-dimensional on-chip mesh. It has five ports, one for the local processing element and one for each of the four neighbours. Each input port holds a small flit buffer per virtual channel. A packet is one or more flits. The head flit carries the destination coordinates, and every flit carries a 2-bit type. Each packet passes through four control steps in order: route computation, output virtual-channel allocation, switch allocation, and crossbar traversal. Each step takes one clock.

Flow control on every link is credit based. The upstream side sends a flit with a virtual-channel number only when it holds a credit for that channel. The router returns one credit pulse per flit that leaves its input buffer. For each downstream virtual channel of each output, the router counts the credits it holds. It sends nothing on a channel whose count is zero. Packets reach distant nodes by repeated hops through neighbouring routers. This block only decides the next hop.

Top module: `vc_mesh_router`

## Requirements
- R1: While reset is held, every `out_valid_o` bit and every `in_credit_o` bit is 0.
- R2: Port index encoding on every port array: 0 local, 1 east, 2 west, 3 north, 4 south. Routing is X first, then Y:
  - destination X greater than the router X goes east, and a smaller X goes west;
  - with X equal, a greater Y goes north and a smaller Y goes south;
  - with both equal, the packet goes to local.
- R3: Flit layout, with the default 18-bit width:
  - bits [17:16] type: 0 head, 1 body, 2 tail, 3 single-flit;
  - bits [15:12] destination X;
  - bits [11:8] destination Y;
  - bits [7:0] payload.
  A flit leaves the router with all its bits unchanged.
- R4: A single-flit packet reaches an idle router that holds credits, driven in cycle n. It is valid at its output in cycle n+4.
- R5: A head flit receives the lowest-numbered free virtual channel of its output. Body and tail flits leave on that same channel. The channel becomes free again once the tail has left. While a packet holds a channel, a new head to the same output gets another channel.
- R6: Once a packet's head has left, each following flit already buffered leaves in the next cycle, as long as credits remain. A non-head flit on an active channel appears two cycles after it is driven.
- R7: The router keeps one credit count per output virtual channel:
  - each count starts at 4;
  - it falls by one for each flit sent on that channel;
  - it rises by one for each `out_credit_i` pulse.
  No flit is sent while the count is zero.
- R8: When a flit leaves input port p, channel v, `in_credit_o[p][v]` pulses for one cycle. The pulse falls in the same cycle that the flit is valid at its output.
- R9: Each output carries at most one flit per cycle. When several inputs compete for one output, round-robin arbitration serves them in turn, so the loser follows one cycle later.
- R10: Each input port sends at most one flit per cycle, so at most one `in_credit_o` bit of a port is set at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| router_x_i | input | COORD_W | X coordinate of this node |
| router_y_i | input | COORD_W | Y coordinate of this node |
| in_valid_i | input | 5 | Flit present on each input port |
| in_vc_i | input | 5 x VC_W | Virtual channel of each incoming flit |
| in_flit_i | input | 5 x FLIT_W | Incoming flit per port |
| in_credit_o | output | 5 x NUM_VCS | Credit return to the upstream side, per input channel |
| out_valid_o | output | 5 | Flit present on each output port |
| out_vc_o | output | 5 x VC_W | Downstream virtual channel of each outgoing flit |
| out_flit_o | output | 5 x FLIT_W | Outgoing flit per port |
| out_credit_i | input | 5 x NUM_VCS | Credit pulses from downstream, per output channel |

## Verification
The hardest case to reach from the ports is a packet stalled part-way through. The downstream credit count must reach zero while body flits of an allocated packet still sit in the input buffer, with the output channel still reserved. The bench stops echoing credits and then streams one six-flit packet into a single channel. This drains the four credits, and the bench confirms that the output stays silent. It then hands back credits one at a time and checks that exactly one more flit leaves for each credit, on the same channel. A second hard case is a head that must pick a second channel because the first is held by an open packet. The bench creates it by interleaving a single-flit packet between the head and the tail of another packet bound for the same output.

// File: rtl/rtr_pkg.sv
package rtr_pkg;
  localparam int NUM_PORTS = 5;

  typedef enum logic [2:0] {
    PORT_LOCAL = 3'd0,
    PORT_EAST  = 3'd1,
    PORT_WEST  = 3'd2,
    PORT_NORTH = 3'd3,
    PORT_SOUTH = 3'd4
  } port_e;

  typedef enum logic [1:0] {
    FT_HEAD = 2'd0,
    FT_BODY = 2'd1,
    FT_TAIL = 2'd2,
    FT_SOLO = 2'd3
  } ftype_e;

  typedef enum logic [1:0] {
    VS_IDLE,
    VS_WAIT_VC,
    VS_ACTIVE
  } vstate_e;

  function automatic logic is_last(input logic [1:0] t);
    return (t == FT_TAIL) || (t == FT_SOLO);
  endfunction
endpackage

// File: rtl/rtr_vc_fifo.sv
module rtr_vc_fifo #(
  parameter int W     = 18,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign do_push = push_i && (cnt_q != CW'(DEPTH));
  assign do_pop  = pop_i && (cnt_q != '0);
  assign dout_o  = mem[rd_q];
  assign empty_o = (cnt_q == '0);

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/rtr_rr_arb.sv
module rtr_rr_arb #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic         adv_i,
  output logic [N-1:0] gnt_o
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] last_q, win;

  // search starts one past the last winner
  always_comb begin
    gnt_o = '0;
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = (int'(last_q) + k) % N;
      if (req_i[idx] && (gnt_o == '0)) gnt_o[idx] = 1'b1;
    end
  end

  always_comb begin
    win = '0;
    for (int k = 0; k < N; k++) if (gnt_o[k]) win = IW'(k);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   last_q <= IW'(N - 1);
    else if (adv_i && (|gnt_o))    last_q <= win;
  end
endmodule

// File: rtl/rtr_route.sv
module rtr_route import rtr_pkg::*; #(
  parameter int COORD_W = 4
) (
  input  logic [COORD_W-1:0] cur_x_i,
  input  logic [COORD_W-1:0] cur_y_i,
  input  logic [COORD_W-1:0] dst_x_i,
  input  logic [COORD_W-1:0] dst_y_i,
  output port_e              port_o
);
  always_comb begin
    if      (dst_x_i > cur_x_i) port_o = PORT_EAST;
    else if (dst_x_i < cur_x_i) port_o = PORT_WEST;
    else if (dst_y_i > cur_y_i) port_o = PORT_NORTH;
    else if (dst_y_i < cur_y_i) port_o = PORT_SOUTH;
    else                        port_o = PORT_LOCAL;
  end
endmodule

// File: rtl/vc_mesh_router.sv
module vc_mesh_router import rtr_pkg::*; #(
  parameter int NUM_VCS   = 3,
  parameter int BUF_DEPTH = 4,
  parameter int COORD_W   = 4,
  parameter int PAYLOAD_W = 8,
  localparam int VC_W     = (NUM_VCS > 1) ? $clog2(NUM_VCS) : 1,
  localparam int FLIT_W   = 2 + 2 * COORD_W + PAYLOAD_W
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [COORD_W-1:0]                  router_x_i,
  input  logic [COORD_W-1:0]                  router_y_i,
  input  logic [NUM_PORTS-1:0]                in_valid_i,
  input  logic [NUM_PORTS-1:0][VC_W-1:0]      in_vc_i,
  input  logic [NUM_PORTS-1:0][FLIT_W-1:0]    in_flit_i,
  output logic [NUM_PORTS-1:0][NUM_VCS-1:0]   in_credit_o,
  output logic [NUM_PORTS-1:0]                out_valid_o,
  output logic [NUM_PORTS-1:0][VC_W-1:0]      out_vc_o,
  output logic [NUM_PORTS-1:0][FLIT_W-1:0]    out_flit_o,
  input  logic [NUM_PORTS-1:0][NUM_VCS-1:0]   out_credit_i
);
  localparam int NIN     = NUM_PORTS * NUM_VCS;
  localparam int CRED_W  = $clog2(BUF_DEPTH + 1);
  localparam int TYPE_HI = FLIT_W - 1;
  localparam int DX_HI   = FLIT_W - 3;
  localparam int DY_HI   = DX_HI - COORD_W;

  logic [FLIT_W-1:0] head_flit [NUM_PORTS][NUM_VCS];
  logic              buf_empty [NUM_PORTS][NUM_VCS];
  logic              pop       [NUM_PORTS][NUM_VCS];
  port_e             rc_port   [NUM_PORTS][NUM_VCS];
  port_e             route_q   [NUM_PORTS][NUM_VCS];
  logic [VC_W-1:0]   ovc_q     [NUM_PORTS][NUM_VCS];
  vstate_e           st_q      [NUM_PORTS][NUM_VCS];

  logic [NUM_VCS-1:0] busy_q [NUM_PORTS];
  logic [CRED_W-1:0]  cred_q [NUM_PORTS][NUM_VCS];

  logic [NIN-1:0]     va_req [NUM_PORTS];
  logic [NIN-1:0]     va_gnt [NUM_PORTS];
  logic [VC_W-1:0]    va_vc  [NUM_PORTS];

  logic [NUM_VCS-1:0]   sai_req  [NUM_PORTS];
  logic [NUM_VCS-1:0]   sai_gnt  [NUM_PORTS];
  logic [VC_W-1:0]      sel_vc   [NUM_PORTS];
  port_e                sel_port [NUM_PORTS];
  logic [NUM_PORTS-1:0] in_has, in_won;
  logic [NUM_PORTS-1:0] sao_req  [NUM_PORTS];
  logic [NUM_PORTS-1:0] sao_gnt  [NUM_PORTS];

  logic [NUM_PORTS-1:0] xb_valid;
  logic [FLIT_W-1:0]    xb_flit [NUM_PORTS];
  logic [VC_W-1:0]      xb_vc   [NUM_PORTS];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_in
    for (genvar v = 0; v < NUM_VCS; v++) begin : g_vc
      rtr_vc_fifo #(.W(FLIT_W), .DEPTH(BUF_DEPTH)) u_buf (
        .clk_i, .rst_ni,
        .push_i  (in_valid_i[p] && (in_vc_i[p] == VC_W'(v))),
        .din_i   (in_flit_i[p]),
        .pop_i   (pop[p][v]),
        .dout_o  (head_flit[p][v]),
        .empty_o (buf_empty[p][v])
      );
      rtr_route #(.COORD_W(COORD_W)) u_rc (
        .cur_x_i (router_x_i),
        .cur_y_i (router_y_i),
        .dst_x_i (head_flit[p][v][DX_HI -: COORD_W]),
        .dst_y_i (head_flit[p][v][DY_HI -: COORD_W]),
        .port_o  (rc_port[p][v])
      );
    end
    rtr_rr_arb #(.N(NUM_VCS)) u_sa_in (
      .clk_i, .rst_ni, .req_i(sai_req[p]), .adv_i(in_won[p]), .gnt_o(sai_gnt[p])
    );
  end

  for (genvar o = 0; o < NUM_PORTS; o++) begin : g_out
    rtr_rr_arb #(.N(NIN)) u_va (
      .clk_i, .rst_ni, .req_i(va_req[o]), .adv_i(|va_req[o]), .gnt_o(va_gnt[o])
    );
    rtr_rr_arb #(.N(NUM_PORTS)) u_sa_out (
      .clk_i, .rst_ni, .req_i(sao_req[o]), .adv_i(|sao_req[o]), .gnt_o(sao_gnt[o])
    );
  end

  // VC allocation: lowest free downstream VC, one grant per output per cycle
  always_comb begin
    for (int o = 0; o < NUM_PORTS; o++) begin
      va_vc[o] = '0;
      for (int w = NUM_VCS - 1; w >= 0; w--) if (!busy_q[o][w]) va_vc[o] = VC_W'(w);
      for (int p = 0; p < NUM_PORTS; p++)
        for (int v = 0; v < NUM_VCS; v++)
          va_req[o][p*NUM_VCS+v] = (st_q[p][v] == VS_WAIT_VC) &&
                                   (route_q[p][v] == port_e'(o)) && !(&busy_q[o]);
    end
  end

  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++)
      for (int v = 0; v < NUM_VCS; v++)
        sai_req[p][v] = (st_q[p][v] == VS_ACTIVE) && !buf_empty[p][v] &&
                        (cred_q[route_q[p][v]][ovc_q[p][v]] != '0);
  end

  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      sel_vc[p] = '0;
      for (int v = 0; v < NUM_VCS; v++) if (sai_gnt[p][v]) sel_vc[p] = VC_W'(v);
      in_has[p]   = |sai_gnt[p];
      sel_port[p] = route_q[p][sel_vc[p]];
    end
    for (int o = 0; o < NUM_PORTS; o++)
      for (int p = 0; p < NUM_PORTS; p++)
        sao_req[o][p] = in_has[p] && (sel_port[p] == port_e'(o));
  end

  // switch grant result and crossbar
  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      in_won[p] = 1'b0;
      for (int o = 0; o < NUM_PORTS; o++) if (sao_gnt[o][p]) in_won[p] = 1'b1;
      for (int v = 0; v < NUM_VCS; v++) pop[p][v] = in_won[p] && sai_gnt[p][v];
    end
    for (int o = 0; o < NUM_PORTS; o++) begin
      xb_valid[o] = 1'b0;
      xb_flit[o]  = '0;
      xb_vc[o]    = '0;
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (sao_gnt[o][p]) begin
          xb_valid[o] = 1'b1;
          xb_flit[o]  = head_flit[p][sel_vc[p]];
          xb_vc[o]    = ovc_q[p][sel_vc[p]];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        for (int v = 0; v < NUM_VCS; v++) begin
          st_q[p][v]    <= VS_IDLE;
          route_q[p][v] <= PORT_LOCAL;
          ovc_q[p][v]   <= '0;
          cred_q[p][v]  <= CRED_W'(BUF_DEPTH);
        end
        busy_q[p] <= '0;
      end
      in_credit_o <= '0;
      out_valid_o <= '0;
      out_vc_o    <= '0;
      out_flit_o  <= '0;
    end else begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        for (int v = 0; v < NUM_VCS; v++) begin
          unique case (st_q[p][v])
            VS_IDLE: if (!buf_empty[p][v]) begin
              route_q[p][v] <= rc_port[p][v];
              st_q[p][v]    <= VS_WAIT_VC;
            end
            VS_WAIT_VC: if (va_gnt[route_q[p][v]][p*NUM_VCS+v]) begin
              ovc_q[p][v] <= va_vc[route_q[p][v]];
              st_q[p][v]  <= VS_ACTIVE;
            end
            VS_ACTIVE: if (pop[p][v] && is_last(head_flit[p][v][TYPE_HI -: 2]))
              st_q[p][v] <= VS_IDLE;
            default: st_q[p][v] <= VS_IDLE;
          endcase
          in_credit_o[p][v] <= pop[p][v];
        end
      end
      for (int o = 0; o < NUM_PORTS; o++) begin
        for (int w = 0; w < NUM_VCS; w++) begin
          if ((|va_gnt[o]) && (va_vc[o] == VC_W'(w)))
            busy_q[o][w] <= 1'b1;
          else if (xb_valid[o] && (xb_vc[o] == VC_W'(w)) && is_last(xb_flit[o][TYPE_HI -: 2]))
            busy_q[o][w] <= 1'b0;
          cred_q[o][w] <= cred_q[o][w] + CRED_W'(out_credit_i[o][w])
                          - CRED_W'(xb_valid[o] && (xb_vc[o] == VC_W'(w)));
        end
        out_valid_o[o] <= xb_valid[o];
        out_vc_o[o]    <= xb_vc[o];
        out_flit_o[o]  <= xb_flit[o];
      end
    end
  end
endmodule

// File: rtl/vc_mesh_router_chk.sv
module vc_mesh_router_chk import rtr_pkg::*; #(
  parameter int NUM_VCS   = 3,
  parameter int BUF_DEPTH = 4,
  localparam int VC_W     = (NUM_VCS > 1) ? $clog2(NUM_VCS) : 1
) (
  input logic                              clk_i,
  input logic                              rst_ni,
  input logic [NUM_PORTS-1:0][NUM_VCS-1:0] in_credit_o,
  input logic [NUM_PORTS-1:0]              out_valid_o,
  input logic [NUM_PORTS-1:0][VC_W-1:0]    out_vc_o,
  input logic [NUM_PORTS-1:0][1:0]         out_type_i,
  input logic [NUM_PORTS-1:0][NUM_VCS-1:0] out_credit_i
);
  logic [7:0] chk_cnt [NUM_PORTS][NUM_VCS];
  logic       open_q  [NUM_PORTS][NUM_VCS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int o = 0; o < NUM_PORTS; o++)
        for (int w = 0; w < NUM_VCS; w++) begin
          chk_cnt[o][w] <= 8'(BUF_DEPTH);
          open_q[o][w]  <= 1'b0;
        end
    end else begin
      for (int o = 0; o < NUM_PORTS; o++)
        for (int w = 0; w < NUM_VCS; w++) begin
          chk_cnt[o][w] <= chk_cnt[o][w] + 8'(out_credit_i[o][w])
                           - 8'(out_valid_o[o] && (out_vc_o[o] == VC_W'(w)));
          if (out_valid_o[o] && (out_vc_o[o] == VC_W'(w))) begin
            if (out_type_i[o] == FT_HEAD) open_q[o][w] <= 1'b1;
            else if (is_last(out_type_i[o])) open_q[o][w] <= 1'b0;
          end
        end
    end
  end

  for (genvar o = 0; o < NUM_PORTS; o++) begin : g_o
    AST_VC_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o[o] |-> (int'(out_vc_o[o]) < NUM_VCS)); // R5
    for (genvar w = 0; w < NUM_VCS; w++) begin : g_w
      AST_CREDIT_RESPECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o[o] && (out_vc_o[o] == VC_W'(w))) |-> (chk_cnt[o][w] != 8'd0)); // R7
      AST_BODY_IN_PACKET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o[o] && (out_vc_o[o] == VC_W'(w)) &&
         ((out_type_i[o] == FT_BODY) || (out_type_i[o] == FT_TAIL))) |-> open_q[o][w]); // R5
      AST_HEAD_ON_FREE_VC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o[o] && (out_vc_o[o] == VC_W'(w)) &&
         ((out_type_i[o] == FT_HEAD) || (out_type_i[o] == FT_SOLO))) |-> !open_q[o][w]); // R5
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_p
    AST_ONE_FLIT_PER_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(in_credit_o[p]) <= 1); // R10
  end
endmodule

bind vc_mesh_router vc_mesh_router_chk #(
  .NUM_VCS(NUM_VCS), .BUF_DEPTH(BUF_DEPTH)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .in_credit_o  (in_credit_o),
  .out_valid_o  (out_valid_o),
  .out_vc_o     (out_vc_o),
  .out_type_i   ({out_flit_o[4][FLIT_W-1 -: 2], out_flit_o[3][FLIT_W-1 -: 2],
                  out_flit_o[2][FLIT_W-1 -: 2], out_flit_o[1][FLIT_W-1 -: 2],
                  out_flit_o[0][FLIT_W-1 -: 2]}),
  .out_credit_i (out_credit_i)
);

// File: tb/vc_mesh_router_tb.sv
module vc_mesh_router_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 5, NV = 3, VW = 2, FW = 18;
  localparam int P_LOC = 0, P_E = 1, P_W = 2, P_N = 3, P_S = 4;
  localparam logic [1:0] T_HEAD = 2'd0, T_BODY = 2'd1, T_TAIL = 2'd2, T_SOLO = 2'd3;

  // {in_port, dst_x, dst_y, expected out_port}, router at (5,5)
  localparam logic [13:0] VEC [10] = '{
    {3'd0, 4'd9,  4'd5,  3'd1}, {3'd2, 4'd5,  4'd5,  3'd0},
    {3'd3, 4'd2,  4'd7,  3'd2}, {3'd4, 4'd5,  4'd8,  3'd3},
    {3'd1, 4'd5,  4'd1,  3'd4}, {3'd0, 4'd5,  4'd5,  3'd0},
    {3'd1, 4'd0,  4'd0,  3'd2}, {3'd3, 4'd15, 4'd0,  3'd1},
    {3'd2, 4'd5,  4'd15, 3'd3}, {3'd0, 4'd5,  4'd0,  3'd4}
  };

  logic clk = 1'b0;
  logic rst_ni;
  logic [3:0] router_x_i, router_y_i;
  logic [NP-1:0] in_valid_i;
  logic [NP-1:0][VW-1:0] in_vc_i;
  logic [NP-1:0][FW-1:0] in_flit_i;
  logic [NP-1:0][NV-1:0] in_credit_o;
  logic [NP-1:0] out_valid_o;
  logic [NP-1:0][VW-1:0] out_vc_o;
  logic [NP-1:0][FW-1:0] out_flit_o;
  logic [NP-1:0][NV-1:0] out_credit_i;

  int checks = 0, errors = 0;
  bit echo = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  vc_mesh_router u_dut (
    .clk_i(clk), .rst_ni, .router_x_i, .router_y_i,
    .in_valid_i, .in_vc_i, .in_flit_i, .in_credit_o,
    .out_valid_o, .out_vc_o, .out_flit_o, .out_credit_i
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // advance to next negedge, clear inputs, echo credits for visible flits
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    in_valid_i   = '0;
    in_vc_i      = '0;
    in_flit_i    = '0;
    out_credit_i = '0;
    if (echo)
      for (int o = 0; o < NP; o++)
        if (out_valid_o[o]) out_credit_i[o][out_vc_o[o]] = 1'b1;
  endtask

  task automatic send(input int p, input int v, input logic [1:0] t,
                      input int dx, input int dy, input int pl);
    in_valid_i[p] = 1'b1;
    in_vc_i[p]    = VW'(v);
    in_flit_i[p]  = {t, 4'(dx), 4'(dy), 8'(pl)};
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int first_pl, cnt;
    rst_ni = 1'b0;
    router_x_i = 4'd5;
    router_y_i = 4'd5;
    in_valid_i = '0; in_vc_i = '0; in_flit_i = '0; out_credit_i = '0;
    repeat (3) @(negedge clk);
    chk(out_valid_o == '0, "R1 out_valid in reset", int'(out_valid_o), 0);
    chk(in_credit_o == '0, "R1 in_credit in reset", int'(in_credit_o), 0);
    rst_ni = 1'b1;
    tick();

    // table: single-flit routing, latency, layout, VC choice, credit return
    for (int i = 0; i < 10; i++) begin
      int ip, dx, dy, ep, v;
      ip = int'(VEC[i][13:11]); dx = int'(VEC[i][10:7]);
      dy = int'(VEC[i][6:3]);   ep = int'(VEC[i][2:0]);
      v  = i % NV;
      tick();
      send(ip, v, T_SOLO, dx, dy, 8'h40 + i);
      repeat (4) tick();
      chk(out_valid_o[ep] == 1'b1, "R4 R2 valid at routed port after 4 cycles", int'(out_valid_o), 1 << ep);
      chk($countones(out_valid_o) == 1, "R9 single output active", int'(out_valid_o), 1 << ep);
      chk(out_flit_o[ep] == {T_SOLO, 4'(dx), 4'(dy), 8'(8'h40 + i)}, "R3 flit unchanged",
          int'(out_flit_o[ep]), int'({T_SOLO, 4'(dx), 4'(dy), 8'(8'h40 + i)}));
      chk(out_vc_o[ep] == 2'd0, "R5 lowest free VC", int'(out_vc_o[ep]), 0);
      chk(in_credit_o[ip][v] == 1'b1 && $countones(in_credit_o) == 1, "R8 credit pulse",
          int'(in_credit_o), 1 << (ip*NV + v));
      tick();
      chk(in_credit_o == '0, "R8 credit pulse one cycle", int'(in_credit_o), 0);
    end

    // R5: second head to same output takes next VC while packet open
    tick();
    send(P_W, 0, T_HEAD, 9, 5, 8'hA0);
    tick();
    send(P_LOC, 0, T_SOLO, 9, 5, 8'hB0);
    repeat (3) tick();
    chk(out_valid_o[P_E] && out_flit_o[P_E][7:0] == 8'hA0, "R5 head out", int'(out_flit_o[P_E][7:0]), 'hA0);
    chk(out_vc_o[P_E] == 2'd0, "R5 head on vc0", int'(out_vc_o[P_E]), 0);
    tick();
    chk(out_valid_o[P_E] && out_flit_o[P_E][7:0] == 8'hB0, "R5 solo out", int'(out_flit_o[P_E][7:0]), 'hB0);
    chk(out_vc_o[P_E] == 2'd1, "R5 solo takes vc1", int'(out_vc_o[P_E]), 1);
    send(P_W, 0, T_BODY, 0, 0, 8'hA1);
    tick();
    send(P_W, 0, T_TAIL, 0, 0, 8'hA2);
    tick();
    chk(out_valid_o[P_E] && out_flit_o[P_E][17:16] == T_BODY, "R6 body two cycles later", int'(out_flit_o[P_E][17:16]), 1);
    chk(out_vc_o[P_E] == 2'd0, "R5 body inherits vc0", int'(out_vc_o[P_E]), 0);
    tick();
    chk(out_valid_o[P_E] && out_flit_o[P_E][17:16] == T_TAIL, "R5 tail out", int'(out_flit_o[P_E][17:16]), 2);
    chk(out_vc_o[P_E] == 2'd0, "R5 tail inherits vc0", int'(out_vc_o[P_E]), 0);
    tick();

    // R6 and R7: six-flit packet with no credit return
    echo = 1'b0;
    tick();
    for (int k = 0; k < 6; k++) begin
      send(P_W, 1, (k == 0) ? T_HEAD : ((k == 5) ? T_TAIL : T_BODY), 9, 5, 8'hC0 + k);
      tick();
    end
    // now at negedge 6: flits visible at 4,5,6; check stream then stall
    cnt = 0;
    chk(out_valid_o[P_E] && out_flit_o[P_E][7:0] == 8'hC2, "R6 consecutive body", int'(out_flit_o[P_E][7:0]), 'hC2);
    tick();
    chk(out_valid_o[P_E] && out_flit_o[P_E][7:0] == 8'hC3, "R6 fourth flit", int'(out_flit_o[P_E][7:0]), 'hC3);
    for (int k = 0; k < 8; k++) begin
      tick();
      if (out_valid_o[P_E]) cnt++;
    end
    chk(cnt == 0, "R7 no send at zero credit", cnt, 0);
    out_credit_i[P_E][0] = 1'b1;
    tick(); tick();
    chk(out_valid_o[P_E] && out_flit_o[P_E][7:0] == 8'hC4, "R7 one flit per credit", int'(out_flit_o[P_E][7:0]), 'hC4);
    tick();
    chk(!out_valid_o[P_E], "R7 stalls again", int'(out_valid_o[P_E]), 0);
    out_credit_i[P_E][0] = 1'b1;
    tick(); tick();
    chk(out_valid_o[P_E] && out_flit_o[P_E][17:16] == T_TAIL, "R7 tail after credit", int'(out_flit_o[P_E][17:16]), 2);
    echo = 1'b1;
    for (int k = 0; k < 3; k++) begin
      tick();
      out_credit_i[P_E][0] = 1'b1;
    end
    tick(); tick();

    // R9: two inputs to east in same cycle
    send(P_LOC, 0, T_SOLO, 9, 5, 8'hD0);
    send(P_N, 0, T_SOLO, 9, 5, 8'hD1);
    repeat (4) tick();
    chk($countones(out_valid_o) == 1 && out_valid_o[P_E], "R9 one winner first", int'(out_valid_o), 2);
    first_pl = int'(out_flit_o[P_E][7:0]);
    chk(first_pl == 'hD0 || first_pl == 'hD1, "R9 winner payload", first_pl, 'hD0);
    tick();
    chk(out_valid_o[P_E] && int'(out_flit_o[P_E][7:0]) == (first_pl ^ 1), "R9 loser next cycle",
        int'(out_flit_o[P_E][7:0]), first_pl ^ 1);
    tick();
    chk(out_valid_o == '0, "R9 idle after both", int'(out_valid_o), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule